// File: doc/BRIEF.md
# Configurable SPI Host Shift Engine

This block is the serial core of an SPI host. It takes words from a transmit FIFO through a pop strobe, shifts each word out on MOSI with the most significant bit first, and collects the same number of bits from MISO into a received word. It then pushes that word into a receive FIFO. The serial clock comes from a 9-bit divisor applied to the system clock. The word width is 8, 16 or 32 bits. Separate control inputs choose the idle level of the clock, the edge on which data is launched, and whether MISO is sampled in the middle or at the end of each bit.

Words run back to back with no gap for as long as the transmit FIFO has data. When the FIFO is empty the clock returns to its idle level. The engine can also drive an active-low slave select by itself. The divisor and the width code are captured at the start of each word, so software may change them while a word is in flight without corrupting it. If the receive FIFO is full when a word finishes, the engine keeps running and reports an overflow instead of pushing.

Top module: `spi_host_engine`

## Requirements
- R1: Every bit lasts 2·(div+1) clock cycles, where div is `baud_div_i`, so an N-bit word lasts 2·N·(div+1) cycles from the edge that pops it to the edge that pops the next one.
- R2: `width_code_i` selects the word size: 0 = 8 bits, 1 = 16 bits, 2 and 3 = 32 bits. Only the low N bits of the transmit word are sent, MSB first. The received word is right-aligned in `rx_data_o` with the upper bits zero.
- R3: Whenever no word is being shifted, including during reset, `sck_o` equals `ck_idle_hi_i`.
- R4: With `tx_on_trail_i` = 0, SCK sits at the active level (the inverse of `ck_idle_hi_i`) for the first half of each bit and at the idle level for the second half. With `tx_on_trail_i` = 1 the two halves are swapped. MOSI changes only at bit boundaries.
- R5: With `smp_late_i` = 0, MISO is captured in the last clock cycle of the first half of each bit. With `smp_late_i` = 1, it is captured in the last clock cycle of the second half.
- R6: Unless both `en_i` and `host_en_i` are high, the engine is idle: it does not pop, SCK stays at the idle level and slave select is released.
- R7: With `auto_ss_i` high and the engine enabled, `ss_no` is low while the transmit FIFO is non-empty or a word is in flight, and high otherwise. With `auto_ss_i` low, `ss_no` stays high.
- R8: If `tx_valid_i` is high in the last cycle of a word, the next word is popped in that same cycle and starts with no idle gap.
- R9: If `rx_full_i` is high when a finished word is presented, `rx_ovf_o` pulses for one cycle in place of `rx_push_o`, and shifting carries on.
- R10: Changes to `baud_div_i` and `width_code_i` while a word is in flight affect only words popped after the change.
- R11: `tx_pop_o` is asserted only when `tx_valid_i` is high, once per word. The received word is presented for one cycle, in the cycle after that word's last clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| host_en_i | input | 1 | Host mode enable |
| ck_idle_hi_i | input | 1 | SCK idle level is high |
| tx_on_trail_i | input | 1 | Launch data on the active-to-idle edge |
| smp_late_i | input | 1 | Sample MISO at the end of the bit |
| auto_ss_i | input | 1 | Engine drives slave select |
| width_code_i | input | 2 | Word size code |
| baud_div_i | input | 9 | Baud divisor |
| tx_valid_i | input | 1 | Transmit FIFO non-empty |
| tx_data_i | input | 32 | Transmit FIFO head word |
| tx_pop_o | output | 1 | Pop transmit FIFO |
| rx_push_o | output | 1 | Push received word |
| rx_data_o | output | 32 | Received word |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_ovf_o | output | 1 | Received word dropped, FIFO full |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Slave select, active low |

## Verification
The bench sweeps every width code, both clock idle levels, both launch edges, both sample points and two divisors, sending pairs of back-to-back words in each case. SCK and MOSI are compared with a bit-timing model in every clock cycle. MISO is driven with one pattern in the first half of each bit and its complement in the second half, so a received word shows exactly which half was sampled, and a swapped sample point shows up as an inverted word. The time between pops shows both the bit length and the absence of gaps. Further runs cover the two enable inputs, a full receive FIFO, and a mid-word change of divisor and width, where the word lengths before and after the change show when the new settings took effect.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned MAX_W     = 32;
  localparam int unsigned BIT_CNT_W = $clog2(MAX_W + 1);

  function automatic logic [BIT_CNT_W-1:0] code_to_bits(input logic [1:0] code);
    case (code)
      2'd0:    return BIT_CNT_W'(8);
      2'd1:    return BIT_CNT_W'(16);
      default: return BIT_CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             phase_o,
  output logic             phase_end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign phase_end_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (cnt_q == div_i) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [MAX_W-1:0]     load_word_i,
  input  logic [BIT_CNT_W-1:0] load_bits_i,
  input  logic [BIT_CNT_W-1:0] nbits_i,
  input  logic                 advance_i,
  input  logic                 sample_i,
  input  logic                 miso_i,
  output logic                 mosi_o,
  output logic [MAX_W-1:0]     rx_word_o
);
  logic [MAX_W-1:0] tx_q, rx_q, rx_cur, rx_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      // left-align so the word MSB sits at the shift-out position
      tx_q <= load_word_i << (MAX_W - load_bits_i);
      rx_q <= '0;
    end else begin
      if (advance_i) tx_q <= tx_q << 1;
      if (sample_i)  rx_q <= {rx_q[MAX_W-2:0], miso_i};
    end
  end

  // include a sample landing on the final cycle of the word
  assign rx_cur    = sample_i ? {rx_q[MAX_W-2:0], miso_i} : rx_q;
  assign rx_mask   = ~({MAX_W{1'b1}} << nbits_i);
  assign rx_word_o = rx_cur & rx_mask;
  assign mosi_o    = tx_q[MAX_W-1];
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             host_en_i,
  input  logic             ck_idle_hi_i,
  input  logic             tx_on_trail_i,
  input  logic             smp_late_i,
  input  logic             auto_ss_i,
  input  logic [1:0]       width_code_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             tx_valid_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [MAX_W-1:0] rx_data_o,
  input  logic             rx_full_i,
  output logic             rx_ovf_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             ss_no
);
  logic                 active;
  logic                 busy_q;
  logic [BIT_CNT_W-1:0] bit_q, nbits_q;
  logic [DIV_W-1:0]     div_q;
  logic                 phase, phase_end;
  logic                 bit_end, last_bit, word_end;
  logic                 sample, advance;
  logic                 shift_mosi;
  logic [MAX_W-1:0]     rx_word;
  logic                 rx_vld_q;
  logic [MAX_W-1:0]     rx_data_q;

  assign active = en_i & host_en_i;

  spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_q),
    .div_i       (div_q),
    .phase_o     (phase),
    .phase_end_o (phase_end)
  );

  assign bit_end  = busy_q & phase & phase_end;
  assign last_bit = (bit_q == nbits_q - 1'b1);
  assign word_end = bit_end & last_bit;
  assign advance  = bit_end & ~last_bit;
  assign sample   = busy_q & phase_end & (smp_late_i ? phase : ~phase);

  // pop from idle, or chain straight out of the last cycle of a word
  assign tx_pop_o = active & tx_valid_i & (~busy_q | word_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      nbits_q <= BIT_CNT_W'(8);
      div_q   <= '0;
    end else if (!active) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
    end else if (tx_pop_o) begin
      busy_q  <= 1'b1;
      bit_q   <= '0;
      nbits_q <= code_to_bits(width_code_i);
      div_q   <= baud_div_i;
    end else if (word_end) begin
      busy_q <= 1'b0;
    end else if (bit_end) begin
      bit_q <= bit_q + 1'b1;
    end
  end

  spi_eng_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tx_pop_o),
    .load_word_i (tx_data_i),
    .load_bits_i (code_to_bits(width_code_i)),
    .nbits_i     (nbits_q),
    .advance_i   (advance),
    .sample_i    (sample),
    .miso_i      (miso_i),
    .mosi_o      (shift_mosi),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_vld_q  <= 1'b0;
      rx_data_q <= '0;
    end else begin
      rx_vld_q <= active & word_end;
      if (active & word_end) rx_data_q <= rx_word;
    end
  end

  assign rx_push_o = rx_vld_q & ~rx_full_i;
  assign rx_ovf_o  = rx_vld_q & rx_full_i;
  assign rx_data_o = rx_data_q;

  assign sck_o  = busy_q ? (ck_idle_hi_i ^ (tx_on_trail_i ? phase : ~phase)) : ck_idle_hi_i;
  assign mosi_o = busy_q & shift_mosi;
  assign ss_no  = ~(active & auto_ss_i & (busy_q | tx_valid_i));
endmodule

// File: rtl/spi_host_engine_chk.sv
module spi_host_engine_chk #(
  parameter int unsigned DIV_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             host_en_i,
  input logic             ck_idle_hi_i,
  input logic             auto_ss_i,
  input logic             tx_valid_i,
  input logic             tx_pop_o,
  input logic             rx_push_o,
  input logic             rx_ovf_o,
  input logic             rx_full_i,
  input logic             sck_o,
  input logic             ss_no,
  input logic             busy_i,
  input logic [DIV_W-1:0] div_i,
  input logic [5:0]       nbits_i
);
  p_pop_has_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_valid_i);

  p_push_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_o || rx_ovf_o) |=> !(rx_push_o || rx_ovf_o));

  p_disabled_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && host_en_i) |-> (!tx_pop_o && ss_no && sck_o == ck_idle_hi_i));

  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_o == ck_idle_hi_i);

  p_ss_manual_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_ss_i |-> ss_no);

  p_ovf_when_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |-> (rx_full_i && !rx_push_o));

  p_cfg_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tx_pop_o) |=> ($stable(div_i) && $stable(nbits_i)));
endmodule

bind spi_host_engine spi_host_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .host_en_i    (host_en_i),
  .ck_idle_hi_i (ck_idle_hi_i),
  .auto_ss_i    (auto_ss_i),
  .tx_valid_i   (tx_valid_i),
  .tx_pop_o     (tx_pop_o),
  .rx_push_o    (rx_push_o),
  .rx_ovf_o     (rx_ovf_o),
  .rx_full_i    (rx_full_i),
  .sck_o        (sck_o),
  .ss_no        (ss_no),
  .busy_i       (busy_q),
  .div_i        (div_q),
  .nbits_i      (nbits_q)
);

// File: tb/spi_host_engine_bench.sv
module spi_host_engine_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, en, host_en, cpol, trail, late, auto_ss, rx_full, miso;
  logic [1:0]  wcode;
  logic [8:0]  div;
  logic        tx_valid, pop, push, ovf, sck, mosi, ss_n;
  logic [31:0] tx_data, rx_data;

  logic [31:0] fifo [0:15];
  int rd = 0, wr = 0;
  assign tx_valid = (rd != wr);
  assign tx_data  = fifo[rd % 16];

  spi_host_engine u_spi_host_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .host_en_i(host_en),
    .ck_idle_hi_i(cpol), .tx_on_trail_i(trail), .smp_late_i(late),
    .auto_ss_i(auto_ss), .width_code_i(wcode), .baud_div_i(div),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(pop),
    .rx_push_o(push), .rx_data_o(rx_data), .rx_full_i(rx_full),
    .rx_ovf_o(ovf), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] pat_a, pat_b;
  logic [31:0] exp_rx [0:255];
  int n_start = 0, n_done = 0, push_cnt = 0, ovf_cnt = 0;
  int trace_err = 0, ss_err = 0, last_iv = 0;
  int c = 0, w_n = 8, w_div = 0;
  logic [31:0] w_data;
  logic in_word = 1'b0, pop_pend = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bits_of(input logic [1:0] code);
    return (code == 2'd0) ? 8 : (code == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] exp_rx_f(input int n, input logic lt,
                                           input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m;
    m = (n == 32) ? 32'hffff_ffff : ((32'd1 << n) - 32'd1);
    return (lt ? b : a) & m;
  endfunction

  // cycle-level model of the serial line
  always @(negedge clk) begin
    logic s_pop, s_push, s_ovf, s_sck, s_mosi, s_ss, s_txv, exp_sck, exp_ss, hb;
    logic [31:0] s_rx;
    int h, b;
    s_pop = pop; s_push = push; s_ovf = ovf; s_sck = sck; s_mosi = mosi;
    s_ss = ss_n; s_txv = tx_valid; s_rx = rx_data;
    if (!rst_n) begin
      c = 0; in_word = 1'b0; pop_pend = 1'b0; miso = 1'b0;
    end else begin
      exp_ss = 1'b1;
      if (pop_pend) begin
        if (in_word) begin
          last_iv = c + 1;
          chk("R1 R8 word interval", c + 1, 2 * w_n * (w_div + 1));
        end
        in_word = 1'b1; c = 0;
        w_n = bits_of(wcode); w_div = int'(div); w_data = fifo[rd % 16];
        rd++;
        exp_rx[n_start % 256] = exp_rx_f(w_n, late, pat_a, pat_b);
        n_start++;
      end else if (in_word) begin
        c++;
        if (c >= 2 * w_n * (w_div + 1)) in_word = 1'b0;
      end
      if (s_push) begin
        chk("R2 R5 R11 received word", s_rx, exp_rx[n_done % 256]);
        push_cnt++; n_done++;
      end else if (s_ovf) begin
        ovf_cnt++; n_done++;
      end
      if (in_word) begin
        h = c / (w_div + 1); b = h / 2; hb = (h % 2) == 1;
        exp_sck = cpol ^ (trail ? hb : ~hb);
        if (s_sck !== exp_sck || s_mosi !== w_data[w_n-1-b]) trace_err++;
        miso = hb ? pat_b[w_n-1-b] : pat_a[w_n-1-b];
      end else begin
        if (s_sck !== cpol) trace_err++;
        miso = 1'b0;
      end
      if (en && host_en && auto_ss && (in_word || s_txv)) exp_ss = 1'b0;
      if (s_ss !== exp_ss) ss_err++;
      pop_pend = s_pop;
    end
  end

  task automatic put(input logic [31:0] d);
    fifo[wr % 16] = d;
    wr++;
  endtask

  task automatic wait_idle();
    int k = 0;
    while ((rd != wr || in_word || pop_pend) && k < 8000) begin
      @(posedge clk); #1; k++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int it, p0, o0, r0;
    rst_n = 1'b0; en = 1'b0; host_en = 1'b0; cpol = 1'b0; trail = 1'b0; late = 1'b0;
    auto_ss = 1'b1; rx_full = 1'b0; wcode = 2'd0; div = 9'd0;
    pat_a = 32'h0; pat_b = 32'h0;
    repeat (4) @(posedge clk); #1;
    chk("R3 reset sck idle", sck, 1'b0);
    chk("R6 reset ss released", ss_n, 1'b1);
    chk("R11 no pop in reset", pop, 1'b0);
    chk("R11 no push in reset", push, 1'b0);
    rst_n = 1'b1; en = 1'b1; host_en = 1'b1;
    @(posedge clk); #1;

    // sweep: width x idle level x launch edge x sample point x divisor
    it = 0;
    for (int wc = 0; wc < 4; wc++) begin
      for (int pol = 0; pol < 2; pol++)
        for (int tr = 0; tr < 2; tr++)
          for (int lt = 0; lt < 2; lt++)
            for (int dv = 0; dv < 2; dv++) begin
              wcode = 2'(wc); cpol = pol[0]; trail = tr[0]; late = lt[0];
              div = (dv == 0) ? 9'd0 : 9'd2;
              auto_ss = (it % 3) != 0;
              pat_a = 32'hA5C3_0F96 ^ (32'(it) * 32'h0101_0101);
              pat_b = ~pat_a;
              @(posedge clk); #1;
              put(32'h3C5A_9617 + 32'(it) * 32'h1357_9BDF);
              put(32'hE1D2_C3B4 ^ (32'(it) * 32'h0F0F_1111));
              wait_idle();
              it++;
            end
      chk($sformatf("R4 sck/mosi timing width code %0d", wc), trace_err, 0);
      chk($sformatf("R7 slave select width code %0d", wc), ss_err, 0);
      chk($sformatf("R3 sck idle after words code %0d", wc), sck, cpol);
    end
    chk("R11 one push per word in sweep", push_cnt, 2 * it);

    // enable gating
    cpol = 1'b1; trail = 1'b0; late = 1'b0; wcode = 2'd0; div = 9'd1; auto_ss = 1'b1;
    pat_a = 32'h0000_005A; pat_b = 32'h0000_00C3;
    en = 1'b0; p0 = rd; r0 = push_cnt;
    put(32'h0000_0081);
    repeat (40) @(posedge clk); #1;
    chk("R6 no pop with block disabled", rd, p0);
    chk("R6 sck idle with block disabled", sck, 1'b1);
    chk("R6 ss released with block disabled", ss_n, 1'b1);
    en = 1'b1; host_en = 1'b0;
    repeat (40) @(posedge clk); #1;
    chk("R6 no pop with host mode off", rd, p0);
    chk("R6 ss released with host mode off", ss_n, 1'b1);
    host_en = 1'b1;
    wait_idle();
    chk("R6 word runs once enabled", push_cnt, r0 + 1);

    // overflow
    rx_full = 1'b1; p0 = push_cnt; o0 = ovf_cnt;
    put(32'h0000_0077);
    wait_idle();
    chk("R9 overflow flagged", ovf_cnt, o0 + 1);
    chk("R9 no push when full", push_cnt, p0);
    rx_full = 1'b0;
    put(32'h0000_0018);
    wait_idle();
    chk("R9 push resumes after full", push_cnt, p0 + 1);

    // config change mid-word
    wcode = 2'd0; div = 9'd1; late = 1'b1;
    pat_a = 32'h1234_5678; pat_b = 32'h9ABC_DEF0;
    put(32'h0000_00A7); put(32'h0000_B00C);
    while (!in_word) begin @(posedge clk); #1; end
    repeat (5) @(posedge clk); #1;
    wcode = 2'd1; div = 9'd3;
    wait_idle();
    chk("R10 first word kept its width and divisor", last_iv, 32);
    chk("R10 later word used new settings", trace_err, 0);
    chk("R7 slave select overall", ss_err, 0);
    finish_run();
  end
endmodule